// File: doc/BRIEF.md
# First-Fit Buffer Page Allocator

This block manages a shared on-chip buffer memory on behalf of up to 64 hardware queues. The memory is divided into 128 pages of 16 32-bit words, and one occupancy bit is kept per page. An allocate request names a queue and a length in words. The block searches for the lowest contiguous run of free pages that can hold that length. It marks the run occupied, records the size code and base page in the queue's entry, and returns the base page.

A release request names a queue only. The block takes the size code and the base page back from that queue's entry, frees the pages and zeroes the entry. Every request goes through a single handshake: the request is accepted while the block is idle, `busy_o` is held high while the work runs, and a one-cycle `done_o` pulse carries a 2-bit status. The pages below the reserved boundary belong to configuration storage, so they are never handed out.

Top module: `page_alloc`

## Requirements
- R1: After reset, `page_map_o` has only bits 0 to 3 set, every queue entry reads zero, and `busy_o` and `done_o` are low.
- R2: An allocate length of 16, 32, 64 or 128 words maps to 1, 2, 4 or 8 pages. Any other length ends with status INVALID (1), and the map and the entries are left unchanged.
- R3: Pages 0 to 3 stay occupied at all times and are never returned as a base, whatever requests are made.
- R4: An allocation grants the lowest base page at which every page of the run is free. Candidate bases advance one page at a time, with no alignment to the run size. On a grant the run's bits are set, the entry is written, the status is OK (0) and `base_o` carries the base.
- R5: The scan tests one candidate base per clock. Counting edges after the accepting edge, `done_o` is high after edge 2+base on a grant, and after edge 2+(128-pages+1) on a no-space result.
- R6: An allocation for a queue whose entry is non-zero ends with status BUSY (2), and the map and the entries are left unchanged.
- R7: When no candidate base b with b+pages <= 128 has a free run, the status is NOSPACE (3), and the map and the entries are left unchanged.
- R8: A release frees pages base to base+pages-1, as taken from the queue's entry. It then zeroes the entry, reports OK and returns the freed base on `base_o`.
- R9: A release of a queue whose entry has base page 0 ends with status INVALID (1), and the map is left unchanged.
- R10: A request is accepted on a rising edge where `req_valid_i` is high and `busy_o` is low. From the next cycle, `busy_o` stays high up to and including the single cycle in which `done_o` is high. Requests presented while `busy_o` is high are ignored.
- R11: An entry is 9 bits wide. Bits [8:7] hold the size code (0, 1, 2, 3 for 1, 2, 4, 8 pages) and bits [6:0] hold the base page. `rd_entry_o` shows the entry of `rd_qid_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 1 | 0 allocate, 1 release |
| req_qid_i | input | 6 | Queue addressed by the request |
| req_words_i | input | 8 | Allocation length in words |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 OK, 1 INVALID, 2 BUSY, 3 NOSPACE; valid with done_o |
| base_o | output | 7 | Granted or freed base page; valid with done_o |
| rd_qid_i | input | 6 | Queue whose entry is shown |
| rd_entry_o | output | 9 | Entry of rd_qid_i |
| page_map_o | output | 128 | Page occupancy bitmap |

## Verification
The hardest case to reach is a no-space result on a fragmented map. It only occurs after many grants have left holes that are too small for the request, and a full scan then takes more than a hundred cycles. The stimulus releases a 2-page run in the low region and refills one page of it, which leaves a 1-page hole. It then fills the upper region with 8-page runs until only a 5-page tail is left. At that point an 8-page request must fail only after it has passed every candidate, while a 1-page request must still land in the hole. A request held on the inputs during a long scan is also covered, to show that it leaves no trace.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_BUSY    = 2'd2,
    ST_NOSPACE = 2'd3
  } pa_status_e;

  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } pa_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_SCAN  = 2'd2,
    S_DONE  = 2'd3
  } pa_state_e;
endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode #(
  parameter int PAGE_WORDS = 16,
  parameter int CODES      = 4,
  parameter int WORDS_W    = 8,
  parameter int CW         = 2
) (
  input  logic [WORDS_W-1:0] words_i,
  output logic [CW-1:0]      code_o,
  output logic               valid_o
);
  always_comb begin
    valid_o = 1'b0;
    code_o  = '0;
    for (int k = 0; k < CODES; k++) begin
      if (words_i == WORDS_W'(PAGE_WORDS << k)) begin
        valid_o = 1'b1;
        code_o  = CW'(k);
      end
    end
  end
endmodule

// File: rtl/pa_window.sv
module pa_window #(
  parameter int PAGES = 128,
  parameter int PW    = 7,
  parameter int CW    = 2
) (
  input  logic [PW:0]      cand_i,
  input  logic [CW-1:0]    code_i,
  output logic [PAGES-1:0] mask_o,
  output logic             fits_o
);
  localparam logic [PW:0] PAGES_V = (PW+1)'(PAGES);

  logic [PW:0] run_len;
  logic [PW:0] end_w;

  assign run_len = (PW+1)'(1) << code_i;
  assign end_w   = cand_i + run_len;
  assign fits_o  = (end_w <= PAGES_V);

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam logic [PW:0] PV = (PW+1)'(p);
    assign mask_o[p] = (PV >= cand_i) && (PV < end_w);
  end
endmodule

// File: rtl/pa_occupancy.sv
module pa_occupancy #(
  parameter int PAGES    = 128,
  parameter int RESERVED = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [PAGES-1:0] mask_i,
  output logic [PAGES-1:0] occ_o
);
  localparam logic [PAGES-1:0] RSV_MASK = {{(PAGES-RESERVED){1'b0}}, {RESERVED{1'b1}}};

  logic [PAGES-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       occ_q <= RSV_MASK;
    else if (set_en_i) occ_q <= occ_q | mask_i;
    else if (clr_en_i) occ_q <= (occ_q & ~mask_i) | RSV_MASK;
  end

  assign occ_o = occ_q;

  AST_RSV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q & RSV_MASK) == RSV_MASK); // R3
  AST_SET_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> (occ_q & mask_i) == '0); // R4
  AST_CLR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> (occ_q & mask_i) == mask_i); // R8
  AST_ONE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i && clr_en_i)); // R8
endmodule

// File: rtl/pa_qtable.sv
module pa_qtable #(
  parameter int QUEUES = 64,
  parameter int QW     = 6,
  parameter int EW     = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [QW-1:0] wqid_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [QW-1:0] aqid_i,
  output logic [EW-1:0] adata_o,
  input  logic [QW-1:0] rqid_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] ent_q [QUEUES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < QUEUES; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[wqid_i] <= wdata_i;
    end
  end

  assign adata_o = ent_q[aqid_i];
  assign rdata_o = ent_q[rqid_i];
endmodule

// File: rtl/page_alloc.sv
module page_alloc
  import page_alloc_pkg::*;
#(
  parameter int PAGES      = 128,
  parameter int PAGE_WORDS = 16,
  parameter int QUEUES     = 64,
  parameter int RESERVED   = 4,
  parameter int CODES      = 4,
  localparam int PW        = $clog2(PAGES),
  localparam int QW        = $clog2(QUEUES),
  localparam int CW        = $clog2(CODES),
  localparam int EW        = PW + CW,
  localparam int WORDS_W   = $clog2(PAGE_WORDS << (CODES-1)) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_op_i,
  input  logic [QW-1:0]      req_qid_i,
  input  logic [WORDS_W-1:0] req_words_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic [PW-1:0]      base_o,
  input  logic [QW-1:0]      rd_qid_i,
  output logic [EW-1:0]      rd_entry_o,
  output logic [PAGES-1:0]   page_map_o
);
  pa_state_e     state_q;
  pa_op_e        op_q;
  pa_status_e    status_q;
  logic [QW-1:0] qid_q;
  logic [CW-1:0] code_q;
  logic          len_ok_q;
  logic [PW:0]   cand_q;
  logic [PW-1:0] base_q;

  logic [CW-1:0]    dec_code;
  logic             dec_ok;
  logic [EW-1:0]    ent;
  logic [PW-1:0]    ent_base;
  logic [CW-1:0]    ent_code;
  logic [PW:0]      win_cand;
  logic [CW-1:0]    win_code;
  logic [PAGES-1:0] win_mask;
  logic             win_fits;
  logic             win_free;
  logic [PAGES-1:0] occ;
  logic             set_en;
  logic             clr_en;
  logic             tbl_we;
  logic [EW-1:0]    tbl_wdata;

  pa_len_decode #(
    .PAGE_WORDS(PAGE_WORDS), .CODES(CODES), .WORDS_W(WORDS_W), .CW(CW)
  ) u_dec (
    .words_i(req_words_i), .code_o(dec_code), .valid_o(dec_ok)
  );

  pa_qtable #(.QUEUES(QUEUES), .QW(QW), .EW(EW)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .wqid_i(qid_q), .wdata_i(tbl_wdata),
    .aqid_i(qid_q), .adata_o(ent),
    .rqid_i(rd_qid_i), .rdata_o(rd_entry_o)
  );

  assign ent_base = ent[PW-1:0];
  assign ent_code = ent[EW-1:PW];

  // scan uses the candidate; release reuses the window on the stored run
  assign win_cand = (state_q == S_SCAN) ? cand_q : {1'b0, ent_base};
  assign win_code = (state_q == S_SCAN) ? code_q : ent_code;

  pa_window #(.PAGES(PAGES), .PW(PW), .CW(CW)) u_win (
    .cand_i(win_cand), .code_i(win_code), .mask_o(win_mask), .fits_o(win_fits)
  );

  pa_occupancy #(.PAGES(PAGES), .RESERVED(RESERVED)) u_occ (
    .clk_i, .rst_ni,
    .set_en_i(set_en), .clr_en_i(clr_en), .mask_i(win_mask), .occ_o(occ)
  );

  assign win_free  = ((occ & win_mask) == '0);
  assign set_en    = (state_q == S_SCAN) && win_fits && win_free;
  assign clr_en    = (state_q == S_CHECK) && (op_q == OP_FREE) && (ent_base != '0);
  assign tbl_we    = set_en || clr_en;
  assign tbl_wdata = set_en ? {code_q, cand_q[PW-1:0]} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_ALLOC;
      status_q <= ST_OK;
      qid_q    <= '0;
      code_q   <= '0;
      len_ok_q <= 1'b0;
      cand_q   <= '0;
      base_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q     <= pa_op_e'(req_op_i);
          qid_q    <= req_qid_i;
          code_q   <= dec_code;
          len_ok_q <= dec_ok;
          state_q  <= S_CHECK;
        end
        S_CHECK: begin
          base_q <= '0;
          if (op_q == OP_ALLOC) begin
            if (!len_ok_q) begin
              status_q <= ST_INVALID;
              state_q  <= S_DONE;
            end else if (ent != '0) begin
              status_q <= ST_BUSY;
              state_q  <= S_DONE;
            end else begin
              cand_q  <= '0;
              state_q <= S_SCAN;
            end
          end else begin
            status_q <= (ent_base == '0) ? ST_INVALID : ST_OK;
            base_q   <= ent_base;
            state_q  <= S_DONE;
          end
        end
        S_SCAN: begin
          if (!win_fits) begin
            status_q <= ST_NOSPACE;
            state_q  <= S_DONE;
          end else if (win_free) begin
            status_q <= ST_OK;
            base_q   <= cand_q[PW-1:0];
            state_q  <= S_DONE;
          end else begin
            cand_q <= cand_q + (PW+1)'(1);
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign status_o   = status_q;
  assign base_o     = base_q;
  assign page_map_o = occ;

  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> (busy_o && !done_o)); // R10
  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_BUSY) |-> $stable(page_map_o)); // R6
  AST_INVALID_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_INVALID) |-> $stable(page_map_o)); // R9
  AST_GRANT_ABOVE_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_OK && op_q == OP_ALLOC) |-> (base_o >= PW'(RESERVED))); // R3
endmodule

// File: tb/page_alloc_bench.sv
`timescale 1ns/1ps
module page_alloc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_op = 1'b0;
  logic [5:0]   req_qid = '0;
  logic [7:0]   req_words = '0;
  logic         busy, done;
  logic [1:0]   status;
  logic [6:0]   base;
  logic [5:0]   rd_qid = '0;
  logic [8:0]   rd_entry;
  logic [127:0] page_map;

  int checks = 0;
  int fails = 0;
  logic [127:0] exp_map;
  logic [8:0]   exp_ent [64];

  always #2.5 clk = ~clk;

  page_alloc u_page_alloc (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_qid_i(req_qid),
    .req_words_i(req_words),
    .busy_o(busy), .done_o(done), .status_o(status), .base_o(base),
    .rd_qid_i(rd_qid), .rd_entry_o(rd_entry), .page_map_o(page_map)
  );

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ff_base(input int len);
    for (int c = 0; c + len <= 128; c++) begin
      logic ok = 1'b1;
      for (int p = c; p < c + len; p++) if (exp_map[p]) ok = 1'b0;
      if (ok) return c;
    end
    return -1;
  endfunction

  function automatic int len_code(input int words);
    case (words)
      16: return 0; 32: return 1; 64: return 2; 128: return 3;
      default: return -1;
    endcase
  endfunction

  // issue one request; returns status, base and edges from accept to done
  task automatic run_req(input logic op, input int qid, input int words,
                         output int st, output int bs, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_qid = 6'(qid); req_words = 8'(words);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "busy after accept", busy, 1'b1);
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    st = status; bs = base;
    @(negedge clk);
    chk("R10", "done one cycle", done, 1'b0);
    chk("R10", "idle after done", busy, 1'b0);
  endtask

  task automatic check_entry(input int qid);
    rd_qid = 6'(qid);
    #1;
    chk("R11", $sformatf("entry q%0d", qid), rd_entry, exp_ent[qid]);
  endtask

  task automatic do_alloc(input int qid, input int words, input string tag);
    int st, bs, lat, code, len, eb, est;
    code = len_code(words);
    len = (code < 0) ? 0 : (1 << code);
    if (code < 0) est = 1;
    else if (exp_ent[qid] != 0) est = 2;
    else begin
      eb = ff_base(len);
      est = (eb < 0) ? 3 : 0;
    end
    run_req(1'b0, qid, words, st, bs, lat);
    chk(tag, $sformatf("alloc q%0d w%0d status", qid, words), st, est);
    if (est == 0) begin
      chk("R4", "granted base", bs, eb);
      chk("R3", "base above reserved", bs >= 4, 1'b1);
      chk("R5", "grant latency", lat, 2 + eb);
      for (int p = eb; p < eb + len; p++) exp_map[p] = 1'b1;
      exp_ent[qid] = {2'(code), 7'(eb)};
    end else if (est == 3) begin
      chk("R5", "nospace latency", lat, 2 + (128 - len + 1));
    end
    chk(tag, "page map", page_map, exp_map);
    check_entry(qid);
  endtask

  task automatic do_free(input int qid, input string tag);
    int st, bs, lat, eb, len;
    eb = exp_ent[qid][6:0];
    len = 1 << exp_ent[qid][8:7];
    run_req(1'b1, qid, 0, st, bs, lat);
    if (eb == 0) begin
      chk(tag, "release zero status", st, 1);
    end else begin
      chk(tag, "release status", st, 0);
      chk(tag, "release base", bs, eb);
      for (int p = eb; p < eb + len; p++) exp_map[p] = 1'b0;
      exp_ent[qid] = '0;
    end
    chk(tag, "page map", page_map, exp_map);
    check_entry(qid);
  endtask

  task automatic t_reset();
    chk("R1", "map at reset", page_map, 128'hF);
    chk("R1", "busy at reset", busy, 1'b0);
    chk("R1", "done at reset", done, 1'b0);
    rd_qid = 6'd0;  #1; chk("R1", "entry q0", rd_entry, 9'd0);
    rd_qid = 6'd63; #1; chk("R1", "entry q63", rd_entry, 9'd0);
  endtask

  task automatic t_bad_len();
    do_alloc(0, 48, "R2");
    do_alloc(0, 8, "R2");
    do_alloc(0, 255, "R2");
  endtask

  task automatic t_first();
    do_alloc(0, 16, "R4");
    do_alloc(1, 32, "R4");
    do_alloc(2, 128, "R4");
    chk("R4", "unaligned run", exp_ent[1], {2'd1, 7'd5});
  endtask

  task automatic t_busy();
    do_alloc(1, 16, "R6");
  endtask

  task automatic t_release();
    do_free(1, "R8");
    do_alloc(3, 16, "R4");
    do_alloc(4, 64, "R4");
  endtask

  task automatic t_rel_zero();
    do_free(10, "R9");
  endtask

  task automatic t_fill();
    int q = 20;
    while (ff_base(8) >= 0 && q < 60) begin
      do_alloc(q, 128, "R4");
      q++;
    end
    do_alloc(q, 128, "R7");
    do_alloc(q + 1, 16, "R4");
    chk("R3", "reserved still set", page_map[3:0], 4'hF);
  endtask

  task automatic t_ignore();
    int lat = 0;
    int dones = 0;
    // free q2 makes a long 8-page hole; then hold a second request during the scan
    do_free(2, "R8");
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_qid = 6'd61; req_words = 8'd128;
    @(posedge clk);
    @(negedge clk);
    req_op = 1'b1; req_qid = 6'd0; req_words = 8'd0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      if (done) dones++;
    end
    req_valid = 1'b0;
    while (busy && lat < 1000) begin
      if (done) dones++;
      @(posedge clk); lat++; @(negedge clk);
    end
    chk("R10", "single completion", dones, 1);
    for (int p = 7; p < 15; p++) exp_map[p] = 1'b1;
    exp_ent[61] = {2'd3, 7'd7};
    chk("R10", "map after ignored request", page_map, exp_map);
    check_entry(0);
    check_entry(61);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_map = 128'hF;
    for (int i = 0; i < 64; i++) exp_ent[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_len();
    t_first();
    t_busy();
    t_release();
    t_rel_zero();
    t_fill();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule